// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two bidirectional data buses, A and B, each `W` bits wide (eight by default). Each direction owns a capture register, a select choosing between the live opposite bus and that stored word, and an output enable. The A-to-B enable is active high and the B-to-A enable is active low. When both are inactive the buses are isolated. The registers keep loading in every state, including isolation.

Each bus is modelled as three groups of signals: the value an outside source drives (`*_in`), a flag that says whether an outside source is driving at all (`*_in_en`), and the block's own drive value (`*_out`) with a per-bit enable (`*_oe`). A bus keeper register per bus holds the last value the bus carried, so an undriven bus keeps its level. The two capture strobes are ordinary inputs that are sampled in the `clk` domain. A register loads on the first `clk` edge at which its strobe is seen high after having been low. The word it loads is the value bus A or bus B carries in that cycle.

Top module: `dual_reg_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both capture registers and both bus keepers to zero. The first cycle after reset that shows the stored words outputs zero on both buses.
- R2: `b_oe` is all ones exactly when `en_ab` is 1 and all zeros when it is 0. While it is all ones, `b_out` carries the A-to-B path result.
- R3: `a_oe` is all ones exactly when `en_ba_n` is 0 and all zeros when it is 1. While it is all ones, `a_out` carries the B-to-A path result.
- R4: `sel_ab` = 0 puts the live bus A value on `b_out`, and `sel_ab` = 1 puts the stored A word there. `sel_ba` does the same for `a_out` with bus B and the stored B word.
- R5: A capture register loads the current value of its own bus in the cycle where its strobe is first seen high after being low. This happens whatever the enables and selects are. A strobe held high does not load again, and the register otherwise keeps its value.
- R6: With `en_ab` = 0 and `en_ba_n` = 1 neither bus is driven, and both registers can still be loaded from the outside values.
- R7: With both directions enabled, both selects at 1 and no strobe, stored A appears on `b_out` and stored B appears on `a_out` in the same cycle.
- R8: While A is driven onto B in real time, a B strobe loads the A value into the B register. The mirror case holds for the B-to-A direction and the A strobe.
- R9: With both directions enabled, both selects at 0 and no outside source on either bus, each bus keeps the value it last carried for as long as that state lasts.
- R10: When both strobes rise in the same cycle with `sel_ab` = 1 and A driven onto B, the B register takes the A word that was stored before that edge. With `sel_ab` = 0, both registers take the live A value.
- R11: Changing a select while the live word equals the stored word leaves the driven output unchanged in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Value an outside source drives on bus A |
| a_in_en | input | 1 | 1 while an outside source drives bus A |
| a_out | output | W | Value this block drives on bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Value an outside source drives on bus B |
| b_in_en | input | 1 | 1 while an outside source drives bus B |
| b_out | output | W | Value this block drives on bus B |
| b_oe | output | W | Per-bit drive enable for bus B |
| en_ab | input | 1 | A-to-B drive enable, active high |
| en_ba_n | input | 1 | B-to-A drive enable, active low |
| sel_ab | input | 1 | A-to-B source: 0 live bus A, 1 stored A word |
| sel_ba | input | 1 | B-to-A source: 0 live bus B, 1 stored B word |
| cap_a | input | 1 | Capture strobe for the A register |
| cap_b | input | 1 | Capture strobe for the B register |

## Verification
Enables, selects and live data reach `a_out`, `b_out`, `a_oe` and `b_oe` through logic with no register, so the bench compares those outputs in the same cycle it changes the inputs. It drives on the falling edge and samples one nanosecond later. A capture or keeper update takes effect at the next rising edge, so a stored word is checked from the cycle after its strobe first rises, through a stored-select readback. A held level is checked in every following cycle of the hold. The bench model takes its updates at that same edge from the values the bus carried before it, and it flags any cycle in which the bench and the block drive the same bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // One bit of a two-way select with the consensus term added, so that
  // equal inputs keep the output steady while the select changes.
  function automatic logic hazfree_bit(input logic s, input logic live, input logic stored);
    return (s & stored) | (~s & live) | (live & stored);
  endfunction

  // True in the first cycle a strobe is seen high after being low.
  function automatic logic first_high(input logic now_lvl, input logic last_lvl);
    return now_lvl & ~last_lvl;
  endfunction
endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = xcvr_pkg::first_high(lvl, lvl_q);
endmodule

// File: rtl/xcvr_word_reg.sv
module xcvr_word_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel #(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = xcvr_pkg::hazfree_bit(sel, live[i], stored[i]);
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         a_in_en,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  input  logic         b_in_en,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_a,
  input  logic         cap_b
);
  logic         a_drive, b_drive;
  logic         loop_hold;
  logic         cap_a_rise, cap_b_rise;
  logic [W-1:0] stored_a, stored_b;
  logic [W-1:0] keep_a, keep_b;
  logic [W-1:0] live_a, live_b;
  logic [W-1:0] vis_a, vis_b;

  assign a_drive = ~en_ba_n;
  assign b_drive = en_ab;
  // Both directions re-drive each other: each bus reinforces its own level.
  assign loop_hold = a_drive & b_drive & ~sel_ab & ~sel_ba;

  // Live value seen by each path: outside source if any, else the keeper.
  assign live_a = a_in_en ? a_in : (loop_hold ? keep_b : keep_a);
  assign live_b = b_in_en ? b_in : (loop_hold ? keep_a : keep_b);

  xcvr_path_sel #(.W(W)) u_sel_ab (.sel(sel_ab), .live(live_a), .stored(stored_a), .y(b_out));
  xcvr_path_sel #(.W(W)) u_sel_ba (.sel(sel_ba), .live(live_b), .stored(stored_b), .y(a_out));

  assign a_oe = {W{a_drive}};
  assign b_oe = {W{b_drive}};

  // Resolved bus levels.
  assign vis_a = a_in_en ? a_in : (a_drive ? a_out : keep_a);
  assign vis_b = b_in_en ? b_in : (b_drive ? b_out : keep_b);

  xcvr_rise_det u_rise_a (.clk(clk), .rst(rst), .lvl(cap_a), .rise(cap_a_rise));
  xcvr_rise_det u_rise_b (.clk(clk), .rst(rst), .lvl(cap_b), .rise(cap_b_rise));

  xcvr_word_reg #(.W(W)) u_reg_a  (.clk(clk), .rst(rst), .load(cap_a_rise), .d(vis_a), .q(stored_a));
  xcvr_word_reg #(.W(W)) u_reg_b  (.clk(clk), .rst(rst), .load(cap_b_rise), .d(vis_b), .q(stored_b));
  xcvr_word_reg #(.W(W)) u_keep_a (.clk(clk), .rst(rst), .load(1'b1),       .d(vis_a), .q(keep_a));
  xcvr_word_reg #(.W(W)) u_keep_b (.clk(clk), .rst(rst), .load(1'b1),       .d(vis_b), .q(keep_b));
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic         a_in_en,
  input logic         b_in_en,
  input logic         en_ab,
  input logic         en_ba_n,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         cap_a_rise,
  input logic         cap_b_rise,
  input logic [W-1:0] vis_a,
  input logic [W-1:0] vis_b,
  input logic [W-1:0] stored_a,
  input logic [W-1:0] stored_b
);
  logic loop_in;
  assign loop_in = en_ab & ~en_ba_n & ~sel_ab & ~sel_ba & ~a_in_en & ~b_in_en;

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stored_a == '0) && (stored_b == '0));

  a_r2_b_quiet: assert property (@(posedge clk) disable iff (rst)
    !en_ab |-> (b_oe == '0));

  a_r3_a_quiet: assert property (@(posedge clk) disable iff (rst)
    en_ba_n |-> (a_oe == '0));

  a_r4_stored_to_b: assert property (@(posedge clk) disable iff (rst)
    (en_ab && sel_ab) |-> (b_out == stored_a));

  a_r4_stored_to_a: assert property (@(posedge clk) disable iff (rst)
    (!en_ba_n && sel_ba) |-> (a_out == stored_b));

  a_r5_load_a: assert property (@(posedge clk) disable iff (rst)
    cap_a_rise |=> (stored_a == $past(vis_a)));

  a_r5_load_b: assert property (@(posedge clk) disable iff (rst)
    cap_b_rise |=> (stored_b == $past(vis_b)));

  a_r5_keep_a: assert property (@(posedge clk) disable iff (rst)
    !cap_a_rise |=> $stable(stored_a));

  a_r5_keep_b: assert property (@(posedge clk) disable iff (rst)
    !cap_b_rise |=> $stable(stored_b));

  a_r9_loop_hold: assert property (@(posedge clk) disable iff (rst)
    (loop_in && $past(loop_in)) |-> ($stable(a_out) && $stable(b_out)));
endmodule

bind dual_reg_xcvr xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .a_in_en(a_in_en), .b_in_en(b_in_en), .en_ab(en_ab), .en_ba_n(en_ba_n),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_a_rise(cap_a_rise), .cap_b_rise(cap_b_rise),
  .vis_a(vis_a), .vis_b(vis_b), .stored_a(stored_a), .stored_b(stored_b)
);

// File: tb/dual_reg_xcvr_tb_top.sv
`timescale 1ns/1ps
module dual_reg_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_in_en = 1'b0, b_in_en = 1'b0;
  logic en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic cap_a = 1'b0, cap_b = 1'b0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  always #2.5 clk = ~clk;

  dual_reg_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_in_en(a_in_en), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_in_en(b_in_en), .b_out(b_out), .b_oe(b_oe),
    .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .cap_a(cap_a), .cap_b(cap_b)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // Behavioural reference state.
  int m_ra = 0, m_rb = 0, m_ka = 0, m_kb = 0;
  bit m_pa = 0, m_pb = 0;
  int last_b = -1;

  task automatic check(input string tag, input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    bit drv_a, drv_b, loop;
    int src_a, src_b, ea, eb, va, vb;
    #1;
    drv_a = !en_ba_n;
    drv_b = en_ab;
    loop  = drv_a && drv_b && !sel_ab && !sel_ba;
    src_a = a_in_en ? int'(a_in) : (loop ? m_kb : m_ka);
    src_b = b_in_en ? int'(b_in) : (loop ? m_ka : m_kb);
    eb = sel_ab ? m_ra : src_a;
    ea = sel_ba ? m_rb : src_b;
    va = a_in_en ? int'(a_in) : (drv_a ? ea : m_ka);
    vb = b_in_en ? int'(b_in) : (drv_b ? eb : m_kb);
    check(tag, !(a_in_en && drv_a) && !(b_in_en && drv_b), "contention", {a_in_en, drv_a, b_in_en, drv_b}, 0);
    check(tag, a_oe === {W{drv_a}} && b_oe === {W{drv_b}}, "oe", {a_oe, b_oe}, {{W{drv_a}}, {W{drv_b}}});
    if (drv_a) check(tag, int'(a_out) === ea, "a_out", int'(a_out), ea);
    if (drv_b) check(tag, int'(b_out) === eb, "b_out", int'(b_out), eb);
    last_b = drv_b ? int'(b_out) : -1;
    @(posedge clk);
    if (rst) begin
      m_ra = 0; m_rb = 0; m_ka = 0; m_kb = 0; m_pa = 0; m_pb = 0;
    end else begin
      if (cap_a && !m_pa) m_ra = va;
      if (cap_b && !m_pb) m_rb = vb;
      m_ka = va; m_kb = vb; m_pa = cap_a; m_pb = cap_b;
    end
    @(negedge clk);
  endtask

  task automatic isolate(input int av, input int bv);
    en_ab = 0; en_ba_n = 1; a_in_en = 1; b_in_en = 1; a_in = av[W-1:0]; b_in = bv[W-1:0];
  endtask

  task automatic read_both();
    a_in_en = 0; b_in_en = 0; en_ab = 1; en_ba_n = 0; sel_ab = 1; sel_ba = 1;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc("R1");
    rst = 0;
    // R1: stored words read back as zero after reset.
    read_both(); cyc("R1");
    // R2 and R3: enables gate each direction; live path with select low.
    isolate(8'h5A, 8'hC3); sel_ab = 0; sel_ba = 0; cyc("R2");
    b_in_en = 0; en_ab = 1; cyc("R2");
    en_ab = 0; b_in_en = 1; b_in = 8'h3C; a_in_en = 0; en_ba_n = 0; cyc("R3");
    // R5 and R6: capture while isolated, held strobes do not reload.
    isolate(8'h11, 8'h22); cap_a = 1; cap_b = 1; cyc("R6");
    a_in = 8'h99; b_in = 8'h88; cyc("R5");
    cap_a = 0; cap_b = 0; cyc("R5");
    // R7: both stored words out at once.
    read_both(); cyc("R7"); cyc("R7");
    // R8: real-time A onto B, B strobe stores A.
    en_ab = 1; sel_ab = 0; en_ba_n = 1; a_in_en = 1; a_in = 8'h6D; b_in_en = 0; cap_b = 1; cyc("R8");
    cap_b = 0; cyc("R8");
    en_ab = 0; a_in_en = 0; en_ba_n = 0; sel_ba = 1; cyc("R8");
    // R8 mirror: real-time B onto A, A strobe stores B.
    sel_ba = 0; b_in_en = 1; b_in = 8'hE4; cap_a = 1; cyc("R8");
    cap_a = 0; cyc("R8");
    en_ba_n = 1; a_in_en = 1; a_in = 8'h01; b_in_en = 0; en_ab = 1; sel_ab = 1; cyc("R8");
    // R9: loop-back hold keeps each bus at its own last level.
    isolate(8'h37, 8'h48); cyc("R9");
    a_in_en = 0; b_in_en = 0; en_ab = 1; en_ba_n = 0; sel_ab = 0; sel_ba = 0;
    for (int i = 0; i < 4; i++) begin
      cyc("R9");
      check("R9", a_out === 8'h37 && b_out === 8'h48, "held", {a_out, b_out}, 16'h3748);
    end
    // R10: coincident strobes with select high take the old stored A.
    isolate(8'h0F, 8'hF0); cap_a = 1; cap_b = 1; cyc("R10");
    cap_a = 0; cap_b = 0; cyc("R10");
    b_in_en = 0; en_ab = 1; sel_ab = 1; a_in = 8'hAA; cap_a = 1; cap_b = 1; cyc("R10");
    cap_a = 0; cap_b = 0; read_both(); cyc("R10");
    check("R10", b_out === 8'hAA && a_out === 8'h0F, "coincident", {a_out, b_out}, 16'h0FAA);
    // R10: coincident strobes with select low both take live A.
    en_ba_n = 1; a_in_en = 1; a_in = 8'h5C; sel_ab = 0; cap_a = 1; cap_b = 1; cyc("R10");
    cap_a = 0; cap_b = 0; read_both(); cyc("R10");
    check("R10", b_out === 8'h5C && a_out === 8'h5C, "coincident low", {a_out, b_out}, 16'h5C5C);
    // R11: equal live and stored words, select toggled, output steady.
    en_ba_n = 1; a_in_en = 1; a_in = 8'h5C; sel_ab = 0;
    for (int i = 0; i < 4; i++) begin
      sel_ab = ~sel_ab; cyc("R11");
      check("R11", last_b == 8'h5C, "steady", last_b, 8'h5C);
    end
    // R4: unequal words, select picks the source.
    a_in = 8'h12; sel_ab = 1; cyc("R4");
    sel_ab = 0; cyc("R4");
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule